// File: doc/BRIEF.md
# Power-Aware Banked RAM Wrapper

This block presents a 4096-word by 4-bit simple dual-port memory. It has one write port and one read port with separate addresses. Inside, the memory is four smaller synchronous RAM banks. Each bank has its own write and read clock enables. A port's enable is combined with that port's user clock enable, and then, depending on the mapping, decoded onto the banks. A bank that takes no part in an access stays idle for that cycle.

A parameter picks the mapping at build time. The first mapping slices by address: four banks of 1024 x 4, with the two top address bits choosing one bank, and an output multiplexer steered by a registered copy of those bits. The second mapping slices by bit: four banks of 4096 x 1, all working on every access, with no decode and no multiplexer. Each bank has a counter of the cycles in which it was enabled, so the two mappings can be compared by activity.

Top module: `banked_ram_wrap`

## Requirements
- R1: A read is accepted when `rd_en` and `rd_ce` are both high. `rd_data` shows the word at `rd_addr` one clock after an accepted read. The word is the last value written there by an earlier accepted write.
- R2: When an accepted read and an accepted write hit the same address in the same cycle, the read returns the value stored before that write.
- R3: With `HORIZ=1`, an accepted access enables only bank `addr[11:10]`. Bit b of `bank_wr_ce` / `bank_rd_ce` is bank b, so at most one bit per port is set in a cycle.
- R4: With `HORIZ=0`, an accepted access sets all four bits of that port's bank-enable vector. Bank b stores data bit b.
- R5: A write is accepted only when `wr_en` and `wr_ce` are both high. When either is low, `bank_wr_ce` is zero and no stored word changes. The read port follows the same rule with `rd_en`/`rd_ce` and `bank_rd_ce`.
- R6: In a cycle with no accepted read, `rd_data` keeps its previous value.
- R7: The counter of bank b, held in `act_cnt[16*b +: 16]`, rises by exactly one in every cycle in which that bank's write or read enable is high. This holds even when both are high. Otherwise the counter holds.
- R8: Holding `rst_n` low at a clock edge clears every activity counter to zero. The reset is synchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset for the counters |
| wr_en | input | 1 | Write request |
| wr_ce | input | 1 | User clock enable of the write port |
| wr_addr | input | 12 | Write word address |
| wr_data | input | 4 | Write word |
| rd_en | input | 1 | Read request |
| rd_ce | input | 1 | User clock enable of the read port |
| rd_addr | input | 12 | Read word address |
| rd_data | output | 4 | Read word, one cycle after the read |
| bank_wr_ce | output | 4 | Per-bank write clock enable |
| bank_rd_ce | output | 4 | Per-bank read clock enable |
| act_cnt | output | 64 | Four 16-bit per-bank activity counters, bank 0 in the low bits |

## Verification
A bank-select register that is wrong in the sliced-by-address mapping shows up in `rd_data` on the very next read whose bank differs from the one before. A wrong decode shows up the same cycle on `bank_wr_ce`/`bank_rd_ce`. A stale or gated-wrong bank shows up at the first read-back of an address that an earlier write should have changed; a full write-then-read sweep reaches every word of every bank within about 8K cycles. Counter faults appear at the next counter comparison, which follows each test phase, and mixed random traffic on both ports exercises read-before-write collisions.

// File: rtl/banked_ram_wrap.sv
module banked_ram_wrap #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 4,
  parameter int NBANK  = 4,
  parameter int HORIZ  = 1,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_ce,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    rd_en,
  input  logic                    rd_ce,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic [NBANK-1:0]        bank_wr_ce,
  output logic [NBANK-1:0]        bank_rd_ce,
  output logic [NBANK*CNT_W-1:0]  act_cnt
);
  localparam int SEL_W = $clog2(NBANK);
  localparam int BAW   = (HORIZ != 0) ? ADDR_W - SEL_W : ADDR_W;
  localparam int BDW   = (HORIZ != 0) ? DATA_W : 1;
  localparam int DEPTH = 1 << BAW;

  wire wr_go = wr_en & wr_ce;
  wire rd_go = rd_en & rd_ce;

  logic [BDW-1:0] bq [NBANK];

  generate
    if (HORIZ != 0) begin : g_horiz
      logic [SEL_W-1:0] sel_q;
      assign bank_wr_ce = wr_go ? NBANK'(1) << wr_addr[ADDR_W-1 -: SEL_W] : '0;
      assign bank_rd_ce = rd_go ? NBANK'(1) << rd_addr[ADDR_W-1 -: SEL_W] : '0;
      always_ff @(posedge clk)
        if (rd_go) sel_q <= rd_addr[ADDR_W-1 -: SEL_W];
      assign rd_data = bq[sel_q];
    end else begin : g_vert
      assign bank_wr_ce = {NBANK{wr_go}};
      assign bank_rd_ce = {NBANK{rd_go}};
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign rd_data[b] = bq[b];
      end
    end
  endgenerate

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int LSB = (HORIZ != 0) ? 0 : b;
    logic [BDW-1:0]   mem [DEPTH];
    logic [BDW-1:0]   q;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (bank_wr_ce[b]) mem[wr_addr[BAW-1:0]] <= wr_data[LSB +: BDW];
      if (bank_rd_ce[b]) q <= mem[rd_addr[BAW-1:0]];
    end

    always_ff @(posedge clk)
      if (!rst_n) cnt <= '0;
      else if (bank_wr_ce[b] | bank_rd_ce[b]) cnt <= cnt + 1'b1;

    assign bq[b] = q;
    assign act_cnt[b*CNT_W +: CNT_W] = cnt;
  end
endmodule

// File: rtl/banked_ram_wrap_chk.sv
module banked_ram_wrap_chk #(
  parameter int DATA_W = 4,
  parameter int NBANK  = 4,
  parameter int HORIZ  = 1,
  parameter int CNT_W  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic                   wr_ce,
  input logic                   rd_en,
  input logic                   rd_ce,
  input logic [DATA_W-1:0]      rd_data,
  input logic [NBANK-1:0]       bank_wr_ce,
  input logic [NBANK-1:0]       bank_rd_ce,
  input logic [NBANK*CNT_W-1:0] act_cnt
);
  if (HORIZ != 0) begin : g_h
    a_r3_one_wr_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ce) |-> $countones(bank_wr_ce) == 1);
    a_r3_one_rd_bank: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_rd_ce));
  end else begin : g_v
    a_r4_all_wr_banks: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ce) |-> &bank_wr_ce);
  end

  a_r5_gated_wr: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_ce) |-> bank_wr_ce == '0);
  a_r5_gated_rd: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_ce) |-> bank_rd_ce == '0);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_ce) |=> $stable(rd_data));
  a_r8_clear: assert property (@(posedge clk)
    !rst_n |=> act_cnt == '0);

  for (genvar b = 0; b < NBANK; b++) begin : g_c
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_wr_ce[b] || bank_rd_ce[b]) |=>
        act_cnt[b*CNT_W +: CNT_W] == $past(act_cnt[b*CNT_W +: CNT_W]) + CNT_W'(1));
    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(bank_wr_ce[b] || bank_rd_ce[b]) |=> $stable(act_cnt[b*CNT_W +: CNT_W]));
  end
endmodule

bind banked_ram_wrap banked_ram_wrap_chk #(
  .DATA_W(DATA_W), .NBANK(NBANK), .HORIZ(HORIZ), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ce(wr_ce), .rd_en(rd_en),
  .rd_ce(rd_ce), .rd_data(rd_data), .bank_wr_ce(bank_wr_ce),
  .bank_rd_ce(bank_rd_ce), .act_cnt(act_cnt)
);

// File: tb/banked_ram_wrap_tb_top.sv
`timescale 1ns/1ps
module banked_ram_wrap_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0, wr_ce = 0, rd_en = 0, rd_ce = 0;
  logic [11:0] wr_addr = 0, rd_addr = 0;
  logic [3:0]  wr_data = 0;
  logic [3:0]  rd_h, rd_v, bw_h, br_h, bw_v, br_v;
  logic [63:0] cnt_h, cnt_v;

  always #2.5 clk = ~clk;

  banked_ram_wrap #(.HORIZ(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ce(wr_ce), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_ce(rd_ce), .rd_addr(rd_addr),
    .rd_data(rd_h), .bank_wr_ce(bw_h), .bank_rd_ce(br_h), .act_cnt(cnt_h));

  banked_ram_wrap #(.HORIZ(0)) dut_v (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ce(wr_ce), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_ce(rd_ce), .rd_addr(rd_addr),
    .rd_data(rd_v), .bank_wr_ce(bw_v), .bank_rd_ce(br_v), .act_cnt(cnt_v));

  int errors = 0, checks = 0;
  logic [3:0]  ref_mem [4096];
  logic [15:0] ec_h [4], ec_v [4];
  logic [3:0]  hold;
  bit          hold_ok = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_cnt(string req);
    for (int b = 0; b < 4; b++) begin
      chk({req, " horiz count"}, cnt_h[b*16 +: 16], ec_h[b]);
      chk({req, " vert count"},  cnt_v[b*16 +: 16], ec_v[b]);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; rd_en = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    for (int b = 0; b < 4; b++) begin ec_h[b] = 0; ec_v[b] = 0; end
  endtask

  task automatic cyc(bit we, bit wce, logic [11:0] wa, logic [3:0] wd,
                     bit re, bit rce, logic [11:0] ra, string rtag);
    logic [3:0] wm_h, rm_h, wm_v, rm_v;
    wr_en = we; wr_ce = wce; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_ce = rce; rd_addr = ra;
    wm_h = (we && wce) ? 4'(1 << wa[11:10]) : 4'h0;
    rm_h = (re && rce) ? 4'(1 << ra[11:10]) : 4'h0;
    wm_v = (we && wce) ? 4'hF : 4'h0;
    rm_v = (re && rce) ? 4'hF : 4'h0;
    #1;
    chk("R3/R5 horiz wr enables", bw_h, wm_h);
    chk("R3/R5 horiz rd enables", br_h, rm_h);
    chk("R4/R5 vert wr enables",  bw_v, wm_v);
    chk("R4/R5 vert rd enables",  br_v, rm_v);
    if (re && rce) begin hold = ref_mem[ra]; hold_ok = 1; end
    if (we && wce) ref_mem[wa] = wd;
    for (int b = 0; b < 4; b++) begin
      ec_h[b] += 16'(wm_h[b] | rm_h[b]);
      ec_v[b] += 16'(wm_v[b] | rm_v[b]);
    end
    @(negedge clk);
    if (hold_ok) begin
      chk({rtag, " horiz rd_data"}, rd_h, hold);
      chk({rtag, " vert rd_data"},  rd_v, hold);
    end
  endtask

  initial begin
    #900000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    chk_cnt("R8");
    for (int a = 0; a < 4096; a++)
      cyc(1, 1, 12'(a), 4'((a * 7 + 3) ^ (a >> 4)), 0, 1, 0, "R1");
    for (int a = 0; a < 4096; a++)
      cyc(0, 1, 0, 0, 1, 1, 12'(a), "R1");
    chk_cnt("R7");
    cyc(1, 0, 12'h805, 4'hA, 1, 0, 12'h805, "R6");
    cyc(0, 1, 12'h805, 4'h5, 1, 0, 12'h805, "R6");
    cyc(1, 1, 12'h000, 4'h0, 0, 0, 12'h805, "R6");
    cyc(0, 0, 0, 0, 1, 1, 12'h805, "R5");
    cyc(1, 1, 12'h123, ~ref_mem[12'h123], 1, 1, 12'h123, "R2");
    cyc(0, 0, 0, 0, 1, 1, 12'h123, "R2");
    cyc(1, 1, 12'h456, 4'h9, 1, 1, 12'h477, "R7");
    cyc(1, 1, 12'hC01, 4'h3, 1, 1, 12'h002, "R7");
    chk_cnt("R7");
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r = $urandom;
      logic [11:0] ra = (r[0]) ? 12'($urandom) : {r[7:4], 8'h11};
      cyc(r[8] | r[9], r[10] | r[11], r[1] ? ra : {r[15:12], 8'h11}, r[19:16],
          r[20] | r[21], r[22] | r[23], ra, "R1/R2");
    end
    chk_cnt("R7");
    do_reset();
    chk_cnt("R8");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule